// File: doc/BRIEF.md
# Accumulator ALU and Condition Flags

This block is the execution core of a small 8-bit accumulator machine. It holds the accumulator and four condition flags (overflow, negative, zero, carry). The fetch and memory side of the processor resolves each instruction's operand and presents it here with the opcode and a one-cycle valid strobe. In the same clock edge the block updates the accumulator and the flags. For branch instructions it raises a one-cycle "jump taken" pulse.

The status byte seen at the output carries the flags in its low half and four sense-switch inputs in its upper half. Because the machine has no general bitwise instructions in its core set, programs test and change individual status bits by numeric weight masks. A flag-test branch is taken when every bit named in its mask is set. A flag-toggle instruction inverts the named flag bits. Accumulator-only shifts and rotates live in their own opcode group and take no operand.

Top module: `acc_alu_core`

## Requirements
- R1: After reset the accumulator reads 0x00, all four flags read 0 and the jump-taken output is low.
- R2: A load (low nibble 0x0 in groups 0x5/0x6) copies the operand into the accumulator and leaves the flags unchanged. A store (0x51/0x61) and opcodes outside groups 0x5, 0x6 and 0xF8–0xFB change nothing.
- R3: ADD (low nibble 0x2) writes A+operand and sets carry (status bit 0) on unsigned carry-out and overflow (bit 3) on signed overflow. Zero (bit 1) and negative (bit 2) follow the 8-bit result.
- R4: SUB (low nibble 0x3) writes A−operand and sets carry when no borrow occurs. Overflow marks signed overflow, and zero and negative follow the result.
- R5: MUL (low nibble 0x8) keeps the low 8 bits of the product and sets both overflow and carry when the product does not fit in 8 bits. Zero and negative follow the kept byte.
- R6: DIV (low nibble 0x9) writes the unsigned quotient and clears overflow and carry. With a zero divisor it leaves the accumulator and the other flags unchanged and sets overflow.
- R7: NOT (0xC) inverts the accumulator and ignores the operand. AND (0xD), OR (0xE) and XOR (0xF) combine the accumulator with the operand. These update zero and negative and keep overflow and carry.
- R8: Opcodes 0xF8/0xF9 rotate the accumulator left/right, and 0xFA/0xFB shift it arithmetically left/right. Each loads carry with the bit shifted out and updates zero and negative. Arithmetic left shift sets overflow when the sign bit changes; the other three keep overflow.
- R9: Status bits 7..4 show sense switches S1..S4, with input bit 3 = S1 at weight 0x80 and input bit 0 = S4 at weight 0x10, one cycle after the input. Bits 3..0 are the O (0x08), N (0x04), Z (0x02) and C (0x01) flags.
- R10: FTG (low nibble 0x7) inverts each flag whose weight is set in the operand's low half. Operand bits 7..4 are ignored.
- R11: JFL (low nibble 0x6) raises jump-taken when every status bit selected by the operand mask is set, sense bits included. An all-zero mask is always taken.
- R12: JMP (0x4) is always taken, JEQ (0x5) when Z is set, JLT (0xA) when N differs from O, and JGT (0xB) when Z is clear and N equals O. Jump-taken is a one-cycle pulse one clock after the strobe, and branches leave the accumulator and flags unchanged.
- R13: With the valid strobe low, the accumulator and flags hold whatever the opcode and operand inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | One-cycle strobe: opcode and operand are valid |
| opcode | input | 8 | Instruction opcode (group in bits 7..4, operation in bits 3..0) |
| operand | input | DATA_W | Resolved operand byte or flag mask |
| sense_sw | input | 4 | Sense switches, bit 3 = S1 .. bit 0 = S4 |
| acc_o | output | DATA_W | Accumulator |
| status_o | output | 8 | Sense switches in bits 7..4, O/N/Z/C flags in bits 3..0 |
| jump_taken_o | output | 1 | One-cycle pulse when the previous strobed branch is taken |

## Verification
The assertions assume that `op_valid` is a clean synchronous strobe with `opcode` and `operand` stable across the sampling edge. They also assume `sense_sw` changes only on clock boundaries, so the one-cycle status view can be compared with the previous cycle's input. The bench drives every input on the falling edge and holds the strobe for exactly one cycle per instruction. It waits out the internal reset synchronizer before the first instruction, so no strobe lands while the core is still held in reset.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int unsigned FLAG_W  = 4;
  localparam int unsigned SENSE_W = 4;
  localparam int unsigned STAT_W  = FLAG_W + SENSE_W;

  localparam logic [3:0] GRP_IMM = 4'h5;
  localparam logic [3:0] GRP_IND = 4'h6;
  localparam logic [3:0] GRP_ACC = 4'hF;

  typedef enum logic [3:0] {
    OP_LDA = 4'h0, OP_STO = 4'h1, OP_ADD = 4'h2, OP_SUB = 4'h3,
    OP_JMP = 4'h4, OP_JEQ = 4'h5, OP_JFL = 4'h6, OP_FTG = 4'h7,
    OP_MUL = 4'h8, OP_DIV = 4'h9, OP_JLT = 4'hA, OP_JGT = 4'hB,
    OP_NOT = 4'hC, OP_AND = 4'hD, OP_OR  = 4'hE, OP_XOR = 4'hF
  } op_lo_e;

  typedef enum logic [1:0] {
    SH_ROL = 2'b00, SH_ROR = 2'b01, SH_ASL = 2'b10, SH_ASR = 2'b11
  } shift_e;

  typedef enum logic [2:0] {
    U_NONE, U_LOAD, U_ARITH, U_LOGIC, U_SHIFT, U_FTG, U_JUMP
  } unit_e;

  typedef struct packed {
    logic ovf;
    logic neg;
    logic zero;
    logic carry;
  } flags_t;

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
  import acc_alu_pkg::*;
(
  input  logic [7:0] opcode,
  output unit_e      unit,
  output op_lo_e     op_lo,
  output shift_e     sh_kind
);

  logic grp_operand;
  logic grp_shift;

  assign op_lo       = op_lo_e'(opcode[3:0]);
  assign sh_kind     = shift_e'(opcode[1:0]);
  assign grp_operand = (opcode[7:4] == GRP_IMM) || (opcode[7:4] == GRP_IND);
  assign grp_shift   = (opcode[7:4] == GRP_ACC) && (opcode[3:2] == 2'b10);

  always_comb begin
    unit = U_NONE;
    if (grp_shift) begin
      unit = U_SHIFT;
    end else if (grp_operand) begin
      case (op_lo)
        OP_LDA:                         unit = U_LOAD;
        OP_STO:                         unit = U_NONE;
        OP_ADD, OP_SUB, OP_MUL, OP_DIV: unit = U_ARITH;
        OP_JMP, OP_JEQ, OP_JFL,
        OP_JLT, OP_JGT:                 unit = U_JUMP;
        OP_FTG:                         unit = U_FTG;
        OP_NOT, OP_AND, OP_OR, OP_XOR:  unit = U_LOGIC;
        default:                        unit = U_NONE;
      endcase
    end
  end

endmodule

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
  import acc_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  op_lo_e            op_lo,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  flags_t            flags_in,
  output logic [DATA_W-1:0] res,
  output flags_t            flags_out
);

  localparam int unsigned PROD_W = 2 * DATA_W;
  localparam int unsigned MSB    = DATA_W - 1;

  logic [DATA_W:0]   sum_w;
  logic [DATA_W:0]   dif_w;
  logic [PROD_W-1:0] prod_w;
  logic [DATA_W-1:0] divisor;
  logic [DATA_W-1:0] quot;
  logic              div_zero;

  assign sum_w    = {1'b0, a} + {1'b0, b};
  assign dif_w    = {1'b0, a} - {1'b0, b};
  assign prod_w   = {{DATA_W{1'b0}}, a} * {{DATA_W{1'b0}}, b};
  assign div_zero = (b == '0);
  assign divisor  = div_zero ? {{(DATA_W-1){1'b0}}, 1'b1} : b;
  assign quot     = a / divisor;

  always_comb begin
    res       = a;
    flags_out = flags_in;
    case (op_lo)
      OP_ADD: begin
        res             = sum_w[DATA_W-1:0];
        flags_out.carry = sum_w[DATA_W];
        flags_out.ovf   = (a[MSB] == b[MSB]) && (sum_w[MSB] != a[MSB]);
      end
      OP_SUB: begin
        res             = dif_w[DATA_W-1:0];
        flags_out.carry = ~dif_w[DATA_W];
        flags_out.ovf   = (a[MSB] != b[MSB]) && (dif_w[MSB] != a[MSB]);
      end
      OP_MUL: begin
        res             = prod_w[DATA_W-1:0];
        flags_out.carry = |prod_w[PROD_W-1:DATA_W];
        flags_out.ovf   = |prod_w[PROD_W-1:DATA_W];
      end
      OP_DIV: begin
        if (div_zero) begin
          res           = a;
          flags_out.ovf = 1'b1;
        end else begin
          res             = quot;
          flags_out.carry = 1'b0;
          flags_out.ovf   = 1'b0;
        end
      end
      default: res = a;
    endcase
    if (!(op_lo == OP_DIV && div_zero)) begin
      flags_out.zero = (res == '0);
      flags_out.neg  = res[MSB];
    end
  end

endmodule

// File: rtl/acc_alu_logic_shift.sv
module acc_alu_logic_shift
  import acc_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              is_shift,
  input  op_lo_e            op_lo,
  input  shift_e            sh_kind,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  flags_t            flags_in,
  output logic [DATA_W-1:0] res,
  output flags_t            flags_out
);

  localparam int unsigned MSB = DATA_W - 1;

  always_comb begin
    res       = a;
    flags_out = flags_in;
    if (is_shift) begin
      case (sh_kind)
        SH_ROL: begin
          res             = {a[MSB-1:0], a[MSB]};
          flags_out.carry = a[MSB];
        end
        SH_ROR: begin
          res             = {a[0], a[MSB:1]};
          flags_out.carry = a[0];
        end
        SH_ASL: begin
          res             = {a[MSB-1:0], 1'b0};
          flags_out.carry = a[MSB];
          flags_out.ovf   = a[MSB] ^ a[MSB-1];
        end
        default: begin
          res             = {a[MSB], a[MSB:1]};
          flags_out.carry = a[0];
        end
      endcase
    end else begin
      case (op_lo)
        OP_NOT:  res = ~a;
        OP_AND:  res = a & b;
        OP_OR:   res = a | b;
        OP_XOR:  res = a ^ b;
        default: res = a;
      endcase
    end
    flags_out.zero = (res == '0);
    flags_out.neg  = res[MSB];
  end

endmodule

// File: rtl/acc_alu_cond.sv
module acc_alu_cond
  import acc_alu_pkg::*;
(
  input  op_lo_e            op_lo,
  input  flags_t            flags,
  input  logic [STAT_W-1:0] status,
  input  logic [STAT_W-1:0] mask,
  output logic              taken
);

  always_comb begin
    case (op_lo)
      OP_JMP:  taken = 1'b1;
      OP_JEQ:  taken = flags.zero;
      OP_JFL:  taken = ((status & mask) == mask);
      OP_JLT:  taken = flags.neg ^ flags.ovf;
      OP_JGT:  taken = ~flags.zero & ~(flags.neg ^ flags.ovf);
      default: taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_valid,
  input  logic [7:0]          opcode,
  input  logic [DATA_W-1:0]   operand,
  input  logic [SENSE_W-1:0]  sense_sw,
  output logic [DATA_W-1:0]   acc_o,
  output logic [STAT_W-1:0]   status_o,
  output logic                jump_taken_o
);

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  unit_e  unit;
  op_lo_e op_lo;
  shift_e sh_kind;

  acc_alu_decode u_dec (
    .opcode  (opcode),
    .unit    (unit),
    .op_lo   (op_lo),
    .sh_kind (sh_kind)
  );

  logic [DATA_W-1:0] acc_q, acc_d;
  flags_t            flags_q, flags_d;
  logic [SENSE_W-1:0] sense_q;
  logic              jump_q, jump_d;
  logic              acc_en, flags_en;

  logic [DATA_W-1:0] ar_res, ls_res;
  flags_t            ar_flags, ls_flags;
  logic              cond_taken;

  acc_alu_arith #(.DATA_W(DATA_W)) u_arith (
    .op_lo     (op_lo),
    .a         (acc_q),
    .b         (operand),
    .flags_in  (flags_q),
    .res       (ar_res),
    .flags_out (ar_flags)
  );

  acc_alu_logic_shift #(.DATA_W(DATA_W)) u_lsh (
    .is_shift  (unit == U_SHIFT),
    .op_lo     (op_lo),
    .sh_kind   (sh_kind),
    .a         (acc_q),
    .b         (operand),
    .flags_in  (flags_q),
    .res       (ls_res),
    .flags_out (ls_flags)
  );

  acc_alu_cond u_cond (
    .op_lo  (op_lo),
    .flags  (flags_q),
    .status ({sense_q, flags_q}),
    .mask   (operand[STAT_W-1:0]),
    .taken  (cond_taken)
  );

  always_comb begin
    acc_d    = acc_q;
    flags_d  = flags_q;
    jump_d   = 1'b0;
    acc_en   = 1'b0;
    flags_en = 1'b0;
    if (op_valid) begin
      case (unit)
        U_LOAD: begin
          acc_d  = operand;
          acc_en = 1'b1;
        end
        U_ARITH: begin
          acc_d    = ar_res;
          flags_d  = ar_flags;
          acc_en   = 1'b1;
          flags_en = 1'b1;
        end
        U_LOGIC, U_SHIFT: begin
          acc_d    = ls_res;
          flags_d  = ls_flags;
          acc_en   = 1'b1;
          flags_en = 1'b1;
        end
        U_FTG: begin
          flags_d  = flags_q ^ flags_t'(operand[FLAG_W-1:0]);
          flags_en = 1'b1;
        end
        U_JUMP:  jump_d = cond_taken;
        default: jump_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      acc_q   <= '0;
      flags_q <= '0;
      sense_q <= '0;
      jump_q  <= 1'b0;
    end else begin
      if (acc_en)   acc_q   <= acc_d;
      if (flags_en) flags_q <= flags_d;
      sense_q <= sense_sw;
      jump_q  <= jump_d;
    end
  end

  assign acc_o        = acc_q;
  assign status_o     = {sense_q, flags_q};
  assign jump_taken_o = jump_q;

endmodule

// File: rtl/acc_alu_checker.sv
module acc_alu_checker #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              op_valid,
  input logic [7:0]        opcode,
  input logic [DATA_W-1:0] operand,
  input logic [3:0]        sense_sw,
  input logic [DATA_W-1:0] acc_o,
  input logic [7:0]        status_o,
  input logic              jump_taken_o
);

  logic grp_ok;
  logic is_branch;
  logic is_add;
  logic is_div;
  logic is_ftg;
  logic [DATA_W:0] add_wide;

  assign grp_ok    = (opcode[7:4] == 4'h5) || (opcode[7:4] == 4'h6);
  assign is_branch = grp_ok && (opcode[3:0] inside {4'h4, 4'h5, 4'h6, 4'hA, 4'hB});
  assign is_add    = grp_ok && (opcode[3:0] == 4'h2);
  assign is_div    = grp_ok && (opcode[3:0] == 4'h9);
  assign is_ftg    = grp_ok && (opcode[3:0] == 4'h7);
  assign add_wide  = {1'b0, acc_o} + {1'b0, operand};

  assert_jump_cause_R12: assert property (@(posedge clk) disable iff (!rst_ok)
    jump_taken_o |-> $past(op_valid && is_branch));

  assert_branch_keeps_acc_R12: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && is_branch) |=> $stable(acc_o) && $stable(status_o[3:0]));

  assert_idle_hold_R13: assert property (@(posedge clk) disable iff (!rst_ok)
    !op_valid |=> $stable(acc_o) && $stable(status_o[3:0]));

  assert_ftg_toggle_R10: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && is_ftg) |=> status_o[3:0] == $past(status_o[3:0] ^ operand[3:0]));

  assert_div_zero_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && is_div && operand == '0) |=> $stable(acc_o) && status_o[3]);

  assert_add_carry_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && is_add) |=> status_o[0] == $past(add_wide[DATA_W]));

  assert_sense_view_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    1'b1 |=> status_o[7:4] == $past(sense_sw));

endmodule

bind acc_alu_core acc_alu_checker #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_ok       (rst_sync_n),
  .op_valid     (op_valid),
  .opcode       (opcode),
  .operand      (operand),
  .sense_sw     (sense_sw),
  .acc_o        (acc_o),
  .status_o     (status_o),
  .jump_taken_o (jump_taken_o)
);

// File: tb/acc_alu_core_bench.sv
`timescale 1ns/1ps
module acc_alu_core_bench;

  logic       clk;
  logic       rst_n;
  logic       op_valid;
  logic [7:0] opcode;
  logic [7:0] operand;
  logic [3:0] sense_sw;
  logic [7:0] acc_o;
  logic [7:0] status_o;
  logic       jump_taken_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  acc_alu_core u_acc_alu_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_valid     (op_valid),
    .opcode       (opcode),
    .operand      (operand),
    .sense_sw     (sense_sw),
    .acc_o        (acc_o),
    .status_o     (status_o),
    .jump_taken_o (jump_taken_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [7:0] op, input logic [7:0] opd);
    @(negedge clk);
    op_valid = 1'b1;
    opcode   = op;
    operand  = opd;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic chk_state(input string tag, input logic [7:0] a, input logic [3:0] f);
    chk({tag, " acc"}, acc_o, a);
    chk({tag, " flags"}, {4'h0, status_o[3:0]}, {4'h0, f});
  endtask

  task automatic t_reset;
    chk("R1 acc", acc_o, 8'h00);
    chk("R1 status", status_o, 8'h00);
    chk("R1 jump", {7'd0, jump_taken_o}, 8'h00);
  endtask

  task automatic t_load;
    issue(8'h50, 8'h3C); chk_state("R2 LDA", 8'h3C, 4'h0);
    issue(8'h51, 8'h99); chk_state("R2 STO", 8'h3C, 4'h0);
    issue(8'h90, 8'h44); chk_state("R2 unused", 8'h3C, 4'h0);
  endtask

  task automatic t_add;
    issue(8'h50, 8'h7F); issue(8'h52, 8'h01); chk_state("R3 sgn ovf", 8'h80, 4'hC);
    issue(8'h50, 8'hFF); issue(8'h62, 8'h01); chk_state("R3 carry", 8'h00, 4'h3);
  endtask

  task automatic t_sub;
    issue(8'h50, 8'h05); issue(8'h53, 8'h05); chk_state("R4 equal", 8'h00, 4'h3);
    issue(8'h50, 8'h03); issue(8'h53, 8'h05); chk_state("R4 borrow", 8'hFE, 4'h4);
    issue(8'h50, 8'h80); issue(8'h53, 8'h01); chk_state("R4 ovf", 8'h7F, 4'h9);
  endtask

  task automatic t_mul;
    issue(8'h50, 8'h10); issue(8'h58, 8'h10); chk_state("R5 wide", 8'h00, 4'hB);
    issue(8'h50, 8'h07); issue(8'h68, 8'h06); chk_state("R5 fits", 8'h2A, 4'h0);
  endtask

  task automatic t_div;
    issue(8'h50, 8'h64); issue(8'h59, 8'h07); chk_state("R6 quot", 8'h0E, 4'h0);
    issue(8'h59, 8'h00); chk_state("R6 by zero", 8'h0E, 4'h8);
  endtask

  task automatic t_logic;
    issue(8'h50, 8'hF0); issue(8'h5D, 8'h0F); chk_state("R7 AND", 8'h00, 4'hA);
    issue(8'h5E, 8'h81); chk_state("R7 OR", 8'h81, 4'hC);
    issue(8'h5F, 8'hFF); chk_state("R7 XOR", 8'h7E, 4'h8);
    issue(8'h5C, 8'h55); chk_state("R7 NOT", 8'h81, 4'hC);
  endtask

  task automatic t_shift;
    issue(8'hF8, 8'h00); chk_state("R8 RSL", 8'h03, 4'h9);
    issue(8'hF9, 8'h00); chk_state("R8 RSR", 8'h81, 4'hD);
    issue(8'hFB, 8'h00); chk_state("R8 ASR", 8'hC0, 4'hD);
    issue(8'hFA, 8'h00); chk_state("R8 ASL keep sign", 8'h80, 4'h5);
    issue(8'hFA, 8'h00); chk_state("R8 ASL sign flip", 8'h00, 4'hB);
  endtask

  task automatic t_sense;
    @(negedge clk);
    sense_sw = 4'b1010;
    @(negedge clk);
    chk("R9 sense view", status_o, 8'hAB);
  endtask

  task automatic t_ftg;
    issue(8'h57, 8'hF5);
    chk("R10 toggle", status_o, 8'hAE);
  endtask

  task automatic t_jfl;
    issue(8'h56, 8'h8A); chk("R11 all set", {7'd0, jump_taken_o}, 8'h01);
    @(negedge clk);       chk("R12 pulse ends", {7'd0, jump_taken_o}, 8'h00);
    issue(8'h56, 8'h41); chk("R11 sense clear", {7'd0, jump_taken_o}, 8'h00);
    issue(8'h66, 8'h00); chk("R11 empty mask", {7'd0, jump_taken_o}, 8'h01);
  endtask

  task automatic t_jumps;
    issue(8'h55, 8'h00); chk("R12 JEQ Z", {7'd0, jump_taken_o}, 8'h01);
    issue(8'h5A, 8'h00); chk("R12 JLT N=O", {7'd0, jump_taken_o}, 8'h00);
    issue(8'h5B, 8'h00); chk("R12 JGT Z", {7'd0, jump_taken_o}, 8'h00);
    issue(8'h57, 8'h0A);
    issue(8'h5A, 8'h00); chk("R12 JLT N", {7'd0, jump_taken_o}, 8'h01);
    issue(8'h5B, 8'h00); chk("R12 JGT N", {7'd0, jump_taken_o}, 8'h00);
    issue(8'h55, 8'h00); chk("R12 JEQ nz", {7'd0, jump_taken_o}, 8'h00);
    issue(8'h57, 8'h04);
    issue(8'h6B, 8'h00); chk("R12 JGT clr", {7'd0, jump_taken_o}, 8'h01);
    issue(8'h54, 8'h00); chk("R12 JMP", {7'd0, jump_taken_o}, 8'h01);
    chk_state("R12 no side effect", 8'h00, 4'h0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    op_valid = 1'b0;
    opcode   = 8'h52;
    operand  = 8'h05;
    @(negedge clk);
    @(negedge clk);
    chk_state("R13 idle", 8'h00, 4'h0);
    issue(8'h57, 8'h0F);
    issue(8'h50, 8'h12); chk_state("R2 LDA keeps flags", 8'h12, 4'hF);
  endtask

  initial begin
    rst_n    = 1'b0;
    op_valid = 1'b0;
    opcode   = 8'h00;
    operand  = 8'h00;
    sense_sw = 4'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_load();
    t_add();
    t_sub();
    t_mul();
    t_div();
    t_logic();
    t_shift();
    t_sense();
    t_ftg();
    t_jfl();
    t_jumps();
    t_idle();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule